// File: doc/BRIEF.md
# Paged Ping-Pong Coordinate Buffer

This block is a two-bank store for object coordinates taken from a video frame. At any moment one bank takes writes from the capture side and the other bank serves reads to a processing stage such as an edge detector. A single-cycle swap pulse exchanges the two roles. The capture side can fill a complete set of coordinates while the processing side works through the previous set, with no copying between the two.

Each bank is organised as pages of bytes. A page number and a byte offset are joined into one linear address inside the bank. The page number sits in the upper bits, so moving between pages needs no output multiplexer. The write side and the read side use separate ports, so a write and a read can happen in the same cycle. Both sides run on one free-running clock and are qualified by synchronous enables. Read data arrives one clock after the request.

Top module: `coord_pingpong_buf`

## Requirements
- R1: Each bank holds 8 pages of 256 bytes, each byte 8 bits wide. The location inside a bank is the 11-bit value {page[2:0], byte[7:0]}, and all 2048 locations of a bank store data independently of one another.
- R2: While rst_n is low, and after it is released, wr_bank_o is 0 (bank 0 takes writes and bank 1 is read), rd_valid_o is 0 and rd_data_o is 0.
- R3: A clock edge with swap_i high inverts wr_bank_o. An edge with swap_i low leaves it unchanged.
- R4: A write presented in the same cycle as swap_i lands in the bank that was the write bank before that edge.
- R5: Read data appears on rd_data_o one clock after rd_en_i is sampled high. rd_valid_o is high exactly in the cycle after an edge with rd_en_i high.
- R6: A read always uses the bank opposite wr_bank_o as it was at the sampling edge. A read presented together with swap_i therefore returns data from the old read bank.
- R7: A write never changes the bank being read. Two reads of the same location with no swap in between return the same byte, even when the write side writes that same address in the meantime.
- R8: rd_data_o keeps its last value in every cycle that follows an edge with rd_en_i low.
- R9: A write and a read presented in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single continuous clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_i | input | 1 | Exchange the write and read roles at this edge |
| wr_en_i | input | 1 | Write qualifier |
| wr_page_i | input | 3 | Page number of the write |
| wr_byte_i | input | 8 | Byte offset of the write inside the page |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Read qualifier |
| rd_page_i | input | 3 | Page number of the read |
| rd_byte_i | input | 8 | Byte offset of the read inside the page |
| rd_data_o | output | 8 | Byte read, one clock after the request |
| rd_valid_o | output | 1 | rd_data_o carries a new byte this cycle |
| wr_bank_o | output | 1 | Index of the bank currently taking writes |

## Verification
The bench goes after the cycle in which a swap, a write and a read all coincide. A design that applied the new bank select too early would store the byte in the bank being read and return data from the wrong bank. It writes every address of one bank while reading the same addresses of the other bank, and re-reads a location whose write-side twin has just been overwritten. A bank decode that leaked writes across banks, or dropped one page bit, would corrupt the read data. It also checks that rd_data_o holds and rd_valid_o drops during idle cycles. A design with a combinational read path or a free-running output register would show up there.

// File: rtl/cpb_pkg.sv
// Package: shared constants, types and address helper for the paged
// ping-pong coordinate buffer. Assumes exactly two banks (ping-pong).
package cpb_pkg;
    localparam int NUM_BANKS    = 2;
    localparam int DEF_PAGE_W   = 3;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_DATA_W   = 8;

    typedef logic bank_idx_t;

    // One-hot bank enable from a bank index, gated by a qualifier.
    function automatic logic [NUM_BANKS-1:0] bank_onehot(input bank_idx_t idx,
                                                         input logic      en);
        logic [NUM_BANKS-1:0] v;
        v = '0;
        if (en) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/cpb_addr_compose.sv
// Module: joins a page number and a byte offset into one linear bank
// address, page in the upper bits. Pure wiring, no state.
module cpb_addr_compose #(
    parameter int PAGE_W = 3,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = PAGE_W + BYTE_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Concatenate page above byte so page selection is plain address decode.
    always_comb begin
        addr_o = {page_i, byte_i};
    end
endmodule

// File: rtl/cpb_role_ctrl.sv
// Module: holds the bank role register and produces per-bank write and
// read enables. Assumes two banks; write bank and read bank are always
// opposite. Also pipelines the read bank and valid flag by one cycle to
// match the synchronous read of the banks.
module cpb_role_ctrl
    import cpb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 swap_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    output bank_idx_t            wr_bank_o,
    output logic [NUM_BANKS-1:0] bank_we_o,
    output logic [NUM_BANKS-1:0] bank_re_o,
    output bank_idx_t            rd_bank_q_o,
    output logic                 rd_valid_o
);
    bank_idx_t sel_q;
    bank_idx_t rd_bank;
    bank_idx_t rd_bank_q;
    logic      rd_valid_q;

    // Role register: toggles on each sampled swap request.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 1'b0;
        else if (swap_i) sel_q <= ~sel_q;
    end

    // Decode the current roles into one-hot enables per bank.
    always_comb begin
        rd_bank   = ~sel_q;
        bank_we_o = bank_onehot(sel_q, wr_en_i);
        bank_re_o = bank_onehot(rd_bank, rd_en_i);
    end

    // Remember which bank answered the read, and flag valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bank_q  <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en_i;
            if (rd_en_i) rd_bank_q <= rd_bank;
        end
    end

    assign wr_bank_o   = sel_q;
    assign rd_bank_q_o = rd_bank_q;
    assign rd_valid_o  = rd_valid_q;
endmodule

// File: rtl/cpb_bank_ram.sv
// Module: one bank, simple dual-port storage with one write port and one
// synchronous read port. The output register resets to zero and holds
// while no read is enabled. The array itself is not reset.
module cpb_bank_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Write port: store on a qualified edge.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Read port: register the addressed byte, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (re_i) rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/coord_pingpong_buf.sv
// Module: top of the paged ping-pong coordinate buffer. Two banks of
// 2**PAGE_W pages x 2**BYTE_W bytes; one is written while the other is
// read, roles exchanged by swap_i. Assumes one continuous clock and
// synchronous active-low reset.
module coord_pingpong_buf
    import cpb_pkg::*;
#(
    parameter int PAGE_W = DEF_PAGE_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_i,
    input  logic              wr_en_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [PAGE_W-1:0] rd_page_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              wr_bank_o
);
    localparam int ADDR_W = PAGE_W + BYTE_W;

    logic [ADDR_W-1:0]    waddr;
    logic [ADDR_W-1:0]    raddr;
    logic [NUM_BANKS-1:0] bank_we;
    logic [NUM_BANKS-1:0] bank_re;
    bank_idx_t            wr_bank;
    bank_idx_t            rd_bank_q;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    cpb_addr_compose #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_waddr (
        .page_i (wr_page_i),
        .byte_i (wr_byte_i),
        .addr_o (waddr)
    );

    cpb_addr_compose #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_raddr (
        .page_i (rd_page_i),
        .byte_i (rd_byte_i),
        .addr_o (raddr)
    );

    cpb_role_ctrl u_roles (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap_i      (swap_i),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .wr_bank_o   (wr_bank),
        .bank_we_o   (bank_we),
        .bank_re_o   (bank_re),
        .rd_bank_q_o (rd_bank_q),
        .rd_valid_o  (rd_valid_o)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        cpb_bank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bank_we[g]),
            .waddr_i (waddr),
            .wdata_i (wr_data_i),
            .re_i    (bank_re[g]),
            .raddr_i (raddr),
            .rdata_o (bank_rdata[g])
        );
    end

    // Select the registered output of the bank that answered the last read.
    always_comb begin
        rd_data_o = bank_rdata[rd_bank_q];
    end

    assign wr_bank_o = wr_bank;
endmodule

// File: rtl/cpb_checker.sv
// Module: temporal checks on the ping-pong buffer, bound to the top.
// Observes ports plus the per-bank enables produced by the role logic.
module cpb_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              swap_i,
    input logic              rd_en_i,
    input logic              wr_bank_o,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [1:0]        bank_we,
    input logic [1:0]        bank_re
);
    assert_swap_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (wr_bank_o != $past(wr_bank_o)));

    assert_no_swap_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(wr_bank_o));

    assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    assert_no_valid_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    assert_write_goes_to_write_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != 2'b00) |-> bank_we[wr_bank_o]);

    assert_single_bank_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we) && $onehot0(bank_re));

    assert_read_bank_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we & bank_re) == 2'b00);
endmodule

bind coord_pingpong_buf cpb_checker #(.DATA_W(DATA_W)) u_cpb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_i     (swap_i),
    .rd_en_i    (rd_en_i),
    .wr_bank_o  (wr_bank_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .bank_we    (bank_we),
    .bank_re    (bank_re)
);

// File: tb/coord_pingpong_buf_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard-driven check of the ping-pong coordinate buffer.
module coord_pingpong_buf_tb;
    localparam int PW    = 3;
    localparam int BW    = 8;
    localparam int DW    = 8;
    localparam int LOCS  = 1 << (PW + BW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          swap_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [PW-1:0] wr_page_i = '0;
    logic [BW-1:0] wr_byte_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          rd_en_i = 1'b0;
    logic [PW-1:0] rd_page_i = '0;
    logic [BW-1:0] rd_byte_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o;
    logic          wr_bank_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] model_mem [2][LOCS];
    logic          model_sel = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    coord_pingpong_buf u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_i     (swap_i),
        .wr_en_i    (wr_en_i),
        .wr_page_i  (wr_page_i),
        .wr_byte_i  (wr_byte_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_page_i  (rd_page_i),
        .rd_byte_i  (rd_byte_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .wr_bank_o  (wr_bank_o)
    );

    function automatic logic [DW-1:0] pat(input int round, input int a);
        return DW'(a * 13 + round * 61 + (a >> 8) * 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: present one cycle of stimulus, update the model, push expected reads.
    task automatic drive(input logic sw, input logic we, input int wa, input logic [DW-1:0] wd,
                         input logic re, input int ra);
        swap_i    = sw;
        wr_en_i   = we;
        wr_page_i = PW'(wa >> BW);
        wr_byte_i = BW'(wa);
        wr_data_i = wd;
        rd_en_i   = re;
        rd_page_i = PW'(ra >> BW);
        rd_byte_i = BW'(ra);
        if (re) exp_q.push_back(model_mem[~model_sel][ra]);
        if (we) model_mem[model_sel][wa] = wd;
        if (sw) model_sel = ~model_sel;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 0, '0, 1'b0, 0);
    endtask

    // Monitor: pop and compare each returned byte (R1 R6 R7 R9).
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R5 actual=unexpected read data %0h expected=none", rd_data_o);
            end else begin
                chk("R1/R6/R7/R9 read data", 32'(rd_data_o), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        // R2: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R2 wr_bank in reset", 32'(wr_bank_o), 0);
        chk("R2 rd_valid in reset", 32'(rd_valid_o), 0);
        chk("R2 rd_data in reset", 32'(rd_data_o), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R2 wr_bank after reset", 32'(wr_bank_o), 0);
        chk("R2 rd_valid after reset", 32'(rd_valid_o), 0);

        // Fill every page of bank 0 (R1)
        for (int a = 0; a < LOCS; a++) drive(1'b0, 1'b1, a, pat(1, a), 1'b0, 0);
        chk("R3 no swap keeps bank", 32'(wr_bank_o), 0);
        drive(1'b1, 1'b0, 0, '0, 1'b0, 0);
        chk("R3 swap flips bank", 32'(wr_bank_o), 1);

        // Fill bank 1 while reading all of bank 0 in the same cycles (R7 R9)
        for (int a = 0; a < LOCS; a++) begin
            drive(1'b0, 1'b1, a, pat(2, a), 1'b1, a);
            if (a == 0) chk("R5 valid one cycle after read", 32'(rd_valid_o), 1);
        end
        idle();
        chk("R5 valid drops when idle", 32'(rd_valid_o), 0);
        held = rd_data_o;
        idle();
        idle();
        chk("R8 data held while idle", 32'(rd_data_o), 32'(held));

        // R7: overwrite the write-bank twin between two reads of one location
        drive(1'b0, 1'b0, 0, '0, 1'b1, 5);
        drive(1'b0, 1'b1, 5, 8'hEE, 1'b1, 5);
        drive(1'b0, 1'b1, 5, 8'hEE, 1'b0, 0);
        drive(1'b0, 1'b0, 0, '0, 1'b1, 5);

        // R4 R6: swap, write and read together in one cycle
        drive(1'b1, 1'b1, 100, 8'hA5, 1'b1, 100);
        chk("R4 swap with write flips bank", 32'(wr_bank_o), 0);
        drive(1'b0, 1'b0, 0, '0, 1'b1, 100);
        drive(1'b0, 1'b0, 0, '0, 1'b1, LOCS - 1);

        // Fill bank 0 again while reading back all of bank 1
        for (int a = 0; a < LOCS; a++) drive(1'b0, 1'b1, a, pat(3, a), 1'b1, a);
        drive(1'b1, 1'b0, 0, '0, 1'b0, 0);
        chk("R3 second swap", 32'(wr_bank_o), 1);

        // Sparse readback of bank 0 across all pages, page 7 byte 255 last
        for (int a = 0; a < LOCS; a += 37) drive(1'b0, 1'b0, 0, '0, 1'b1, a);
        drive(1'b0, 1'b0, 0, '0, 1'b1, LOCS - 1);
        idle();
        idle();
        chk("R5 every read answered", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule